// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block is the hardware state machine that owns a PLL's 32-bit control word. The word drives the PLL's reset, bypass and output-enable lines and holds its divider fields. A requester sends one command at a time. The commands are: change the rate, bring the PLL out of reset (prepare), put it back into reset (unprepare), gate the output on (enable), and gate it off (disable). Two lock-status inputs from the PLL are observed, and the current control word is presented for readback with those two status inputs merged into bits 29:28.

For a rate change the block compares the requested feedback divider with the one it currently holds. If the two differ, it routes the output to the reference clock, holds the PLL in reset, loads both dividers, releases reset, and waits for the basic lock and then the long lock. Only after that does it enable the output and remove the bypass. If the feedback divider is unchanged, it swaps only the output divider, and does so while the bypass is set. Every write to the control word stays on the outputs for at least `HOLD_CYCLES` cycles before the next write, so the PLL sees each intermediate step.

Commands arrive on a valid/ready handshake. `req_ready` is high only while the block is idle, and a command is taken on a clock edge where `req_valid` and `req_ready` are both high. Commands are not back-pressured: a requester that raises `req_valid` while `req_ready` is low has its command dropped, not held, and `req_err` reports the drop.

Top module: `pll_reconfig_seq`

## Requirements
- R1: After reset the control word holds the reset flag (bit 2) set. It holds the feedback divider (bits 27:20), output divider exponent (bits 18:16), reference divider (bits 12:8) and range (bits 6:4) at their parameter values. All other bits are zero. `busy` is low, `req_ready` is high, and `done` and `req_err` are low.
- R2: A rate request whose feedback divider differs from bits 27:20 writes the control word in this order: set bypass (bit 1); set reset (bit 2); load both dividers; clear reset; set enable (bit 0); clear bypass. A step that leaves the word unchanged produces no visible change, and the feedback field changes only while bits 1 and 2 are both set.
- R3: In that full path, enable is not written until basic lock (status bit 28) has been seen and, after it, long lock (bit 29). Long lock alone does not let the sequence advance.
- R4: A rate request whose feedback divider equals bits 27:20 sets bypass, replaces bits 18:16, then restores bit 1 to its value at acceptance. Bits 0 and 2 are untouched, and bits 18:16 change only while bit 1 is set.
- R5: A prepare request (op code 1) clears bit 2. It reports done only after basic lock and then long lock have been seen.
- R6: An unprepare request (op code 2) sets bit 2 and changes nothing else.
- R7: An enable request (op code 3) sets bit 0 and a disable request (op code 4) clears bit 0. Neither changes any other bit.
- R8: Each value written to bits 27:0 is held for at least `HOLD_CYCLES` cycles before the next write.
- R9: A request with `req_valid` high while `req_ready` is low is dropped, and `req_err` is high for one cycle in the following cycle. The command has no effect on the control word.
- R10: Internal bypass (bit 3), range and reference divider never change after reset. Bits 31:30, 19, 15:13 and 7 read zero, and bits 29:28 read the long-lock and basic-lock inputs.
- R11: `done` is a one-cycle pulse in the first idle cycle after the last step, with `busy` low and `req_ready` high. Op codes 5 to 7 are accepted and complete with `done` without changing the word. The rate-change op code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Block idle, command will be taken |
| req_op | input | 3 | 0 rate, 1 prepare, 2 unprepare, 3 enable, 4 disable |
| req_fbdiv | input | 8 | Requested feedback divider (rate command) |
| req_odiv | input | 3 | Requested output divider exponent (rate command) |
| req_err | output | 1 | One-cycle flag: a command was dropped while busy |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| pll_lock | input | 1 | Basic lock status from the PLL |
| pll_lock_long | input | 1 | Long lock qualification from the PLL |
| ctrl_word | output | 32 | Control word driving the PLL, with lock status in bits 29:28 |

## Verification
The bench builds the block with `HOLD_CYCLES` = 2. This makes the minimum hold between consecutive control-word writes observable as a gap of two or more cycles, where a one-cycle design would hide a step being skipped or merged. The reset parameters are set to non-zero feedback (39), output (2), reference-divider (3) and range (5) values. Any corruption of those fields by a step therefore shows in the logged word sequence. A lock-after-delay model with a hold-off on basic lock lets the bench stall the full path with only long lock present.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  localparam int WORD_W   = 32;
  localparam int FB_W     = 8;
  localparam int OD_W     = 3;
  localparam int RANGE_W  = 3;
  localparam int REFDIV_W = 5;
  localparam int OP_W     = 3;

  localparam logic [OP_W-1:0] OP_RATE      = 3'd0;
  localparam logic [OP_W-1:0] OP_PREPARE   = 3'd1;
  localparam logic [OP_W-1:0] OP_UNPREPARE = 3'd2;
  localparam logic [OP_W-1:0] OP_ENABLE    = 3'd3;
  localparam logic [OP_W-1:0] OP_DISABLE   = 3'd4;

  // Field order is fixed: the PLL decodes these positions.
  typedef struct packed {
    logic [1:0]          rsv_hi;
    logic                lk_long;
    logic                lk;
    logic [FB_W-1:0]     fbdiv;
    logic                rsv19;
    logic [OD_W-1:0]     odiv;
    logic [2:0]          rsv_mid;
    logic [REFDIV_W-1:0] refdiv;
    logic                rsv7;
    logic [RANGE_W-1:0]  rng;
    logic                int_byp;
    logic                pll_rst;
    logic                ext_byp;
    logic                out_en;
  } pll_word_t;

  typedef enum logic [4:0] {
    ST_IDLE, ST_F_BYP, ST_F_RST, ST_F_LOAD, ST_F_REL, ST_F_WAIT, ST_F_EN,
    ST_F_UNBYP, ST_Q_BYP, ST_Q_OD, ST_Q_REST, ST_P_REL, ST_P_WAIT,
    ST_U_RST, ST_E_SET, ST_E_CLR, ST_NOP
  } step_e;

  function automatic logic is_wait(step_e s);
    return (s == ST_F_WAIT) || (s == ST_P_WAIT);
  endfunction

  function automatic step_e step_after(step_e s);
    case (s)
      ST_F_BYP:  return ST_F_RST;
      ST_F_RST:  return ST_F_LOAD;
      ST_F_LOAD: return ST_F_REL;
      ST_F_REL:  return ST_F_WAIT;
      ST_F_WAIT: return ST_F_EN;
      ST_F_EN:   return ST_F_UNBYP;
      ST_Q_BYP:  return ST_Q_OD;
      ST_Q_OD:   return ST_Q_REST;
      ST_P_REL:  return ST_P_WAIT;
      default:   return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/pllseq_word_edit.sv
module pllseq_word_edit
  import pllseq_pkg::*;
(
  input  pll_word_t        cur,
  input  step_e            step,
  input  logic [FB_W-1:0]  fbdiv,
  input  logic [OD_W-1:0]  odiv,
  input  logic             saved_byp,
  output pll_word_t        nxt
);
  always_comb begin
    nxt = cur;
    case (step)
      ST_F_BYP, ST_Q_BYP:  nxt.ext_byp = 1'b1;
      ST_F_RST, ST_U_RST:  nxt.pll_rst = 1'b1;
      ST_F_LOAD: begin
        nxt.fbdiv = fbdiv;
        nxt.odiv  = odiv;
      end
      ST_F_REL, ST_P_REL:  nxt.pll_rst = 1'b0;
      ST_F_EN, ST_E_SET:   nxt.out_en  = 1'b1;
      ST_F_UNBYP:          nxt.ext_byp = 1'b0;
      ST_Q_OD:             nxt.odiv    = odiv;
      ST_Q_REST:           nxt.ext_byp = saved_byp;
      ST_E_CLR:            nxt.out_en  = 1'b0;
      default:             nxt = cur;
    endcase
  end
endmodule

// File: rtl/pllseq_hold_timer.sv
module pllseq_hold_timer #(
  parameter int unsigned HOLD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
  localparam logic [CW-1:0] START = CW'((HOLD == 0) ? 0 : HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= START;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pllseq_lock_track.sv
module pllseq_lock_track (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic lock,
  input  logic lock_long,
  output logic locked
);
  logic basic_q, both_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) begin
      basic_q <= 1'b0;
      both_q  <= 1'b0;
    end else begin
      if (lock)                 basic_q <= 1'b1;
      if (basic_q && lock_long) both_q  <= 1'b1;
    end
  end

  assign locked = both_q;
endmodule

// File: rtl/pll_reconfig_seq.sv
module pll_reconfig_seq
  import pllseq_pkg::*;
#(
  parameter int unsigned         HOLD_CYCLES = 1,
  parameter logic [FB_W-1:0]     RST_FBDIV   = 8'd31,
  parameter logic [OD_W-1:0]     RST_ODIV    = 3'd1,
  parameter logic [REFDIV_W-1:0] RST_REFDIV  = 5'd0,
  parameter logic [RANGE_W-1:0]  RST_RANGE   = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_op,
  input  logic [FB_W-1:0]   req_fbdiv,
  input  logic [OD_W-1:0]   req_odiv,
  output logic              req_err,
  output logic              busy,
  output logic              done,
  input  logic              pll_lock,
  input  logic              pll_lock_long,
  output logic [WORD_W-1:0] ctrl_word
);
  localparam pll_word_t RESET_WORD = '{
    rsv_hi: 2'b0, lk_long: 1'b0, lk: 1'b0, fbdiv: RST_FBDIV, rsv19: 1'b0,
    odiv: RST_ODIV, rsv_mid: 3'b0, refdiv: RST_REFDIV, rsv7: 1'b0,
    rng: RST_RANGE, int_byp: 1'b0, pll_rst: 1'b1, ext_byp: 1'b0, out_en: 1'b0
  };

  step_e           st, tgt;
  pll_word_t       word_q, word_nxt;
  logic [FB_W-1:0] fb_q;
  logic [OD_W-1:0] od_q;
  logic            byp_sv;
  logic            enter, finish, expired, locked, idle;

  assign idle = (st == ST_IDLE);

  pllseq_hold_timer #(.HOLD(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(enter), .expired(expired)
  );

  pllseq_lock_track u_lock (
    .clk(clk), .rst_n(rst_n), .arm(is_wait(st)),
    .lock(pll_lock), .lock_long(pll_lock_long), .locked(locked)
  );

  pllseq_word_edit u_edit (
    .cur(word_q), .step(tgt), .fbdiv(fb_q), .odiv(od_q),
    .saved_byp(byp_sv), .nxt(word_nxt)
  );

  // Next step selection: a write step is entered together with its write.
  always_comb begin
    tgt    = st;
    enter  = 1'b0;
    finish = 1'b0;
    if (idle) begin
      if (req_valid) begin
        enter = 1'b1;
        case (req_op)
          OP_RATE:      tgt = (req_fbdiv != word_q.fbdiv) ? ST_F_BYP : ST_Q_BYP;
          OP_PREPARE:   tgt = ST_P_REL;
          OP_UNPREPARE: tgt = ST_U_RST;
          OP_ENABLE:    tgt = ST_E_SET;
          OP_DISABLE:   tgt = ST_E_CLR;
          default:      tgt = ST_NOP;
        endcase
      end
    end else if (is_wait(st) ? locked : expired) begin
      tgt = step_after(st);
      if (tgt == ST_IDLE) finish = 1'b1;
      else if (!is_wait(tgt)) enter = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      word_q  <= RESET_WORD;
      fb_q    <= RST_FBDIV;
      od_q    <= RST_ODIV;
      byp_sv  <= 1'b0;
      done    <= 1'b0;
      req_err <= 1'b0;
    end else begin
      done    <= finish;
      req_err <= req_valid && !idle;
      if (idle && req_valid) begin
        fb_q   <= req_fbdiv;
        od_q   <= req_odiv;
        byp_sv <= word_q.ext_byp;
      end
      if (enter)       word_q <= word_nxt;
      if (finish)      st <= ST_IDLE;
      else if (tgt != st) st <= tgt;
    end
  end

  assign req_ready = idle;
  assign busy      = !idle;
  assign ctrl_word = word_q | {2'b00, pll_lock_long, pll_lock, 28'd0};

endmodule

// File: rtl/pllseq_checker.sv
module pllseq_checker #(
  parameter int unsigned HOLD = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_err,
  input logic        busy,
  input logic        done,
  input logic [31:0] ctrl_word
);
  localparam int CW = $clog2(HOLD + 1) + 1;
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  logic [27:0]   prev_w;
  logic          prev_v;
  logic [CW-1:0] held;
  logic          chg;

  assign chg = prev_v && (ctrl_word[27:0] != prev_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_v <= 1'b0;
      prev_w <= '0;
      held   <= HOLD_C;
    end else begin
      prev_v <= 1'b1;
      prev_w <= ctrl_word[27:0];
      if (chg)               held <= CW'(1);
      else if (held < HOLD_C) held <= held + 1'b1;
    end
  end

  AST_FB_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word[27:20]) |-> (ctrl_word[2] && ctrl_word[1])); // R2
  AST_EN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_word[0]) && ctrl_word[1]) |-> (ctrl_word[29] && ctrl_word[28])); // R3
  AST_OD_UNDER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word[18:16]) |-> ctrl_word[1]); // R4
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (held >= HOLD_C)); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid && !req_ready)); // R9
  AST_STATIC_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ctrl_word[12:3])); // R10
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[31:30] == 2'b00) && !ctrl_word[19] && (ctrl_word[15:13] == 3'b000)); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && req_ready)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
endmodule

bind pll_reconfig_seq pllseq_checker #(.HOLD(HOLD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_err(req_err), .busy(busy), .done(done), .ctrl_word(ctrl_word)
);

// File: tb/tb_pll_reconfig_seq.sv
`timescale 1ns/1ps
module tb_pll_reconfig_seq;
  localparam int HOLD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_err, busy, done;
  logic [2:0] req_op = '0;
  logic [7:0] req_fbdiv = '0;
  logic [2:0] req_odiv = '0;
  logic pll_lock = 1'b0, pll_lock_long = 1'b0;
  logic [31:0] ctrl_word;

  always #2.5 clk = ~clk;

  pll_reconfig_seq #(.HOLD_CYCLES(HOLD), .RST_FBDIV(8'd39), .RST_ODIV(3'd2),
    .RST_REFDIV(5'd3), .RST_RANGE(3'd5)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_fbdiv(req_fbdiv), .req_odiv(req_odiv),
    .req_err(req_err), .busy(busy), .done(done), .pll_lock(pll_lock),
    .pll_lock_long(pll_lock_long), .ctrl_word(ctrl_word));

  int checks = 0, fails = 0, cyc = 0, lk_cnt = 0;
  bit hold_basic = 0, logging = 0, finished = 0;

  // PLL stub: locks some cycles after reset is released.
  always @(negedge clk) begin
    if (!rst_n || ctrl_word[2]) lk_cnt = 0;
    else if (lk_cnt < 1000) lk_cnt++;
    pll_lock      = (lk_cnt >= 6) && !hold_basic;
    pll_lock_long = (lk_cnt >= 14);
  end

  always @(posedge clk) cyc++;

  logic [27:0] seen [16];
  int seen_cyc [16];
  int nseen;
  logic [27:0] last_seen;
  always @(negedge clk) begin
    if (logging && ctrl_word[27:0] != last_seen) begin
      if (nseen < 16) begin seen[nseen] = ctrl_word[27:0]; seen_cyc[nseen] = cyc; end
      nseen++;
      last_seen = ctrl_word[27:0];
    end
  end

  logic [27:0] expv [16];
  int nexp;
  logic [31:0] mw, mlast;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(logic [31:0] w);
    if (w[27:0] != mlast[27:0]) begin
      if (nexp < 16) expv[nexp] = w[27:0];
      nexp++;
      mlast = w;
    end
  endtask

  // Bench model of the command effects.
  task automatic model_op(logic [2:0] op, logic [7:0] fb, logic [2:0] od);
    logic [31:0] w;
    logic sb;
    w = mw; mlast = mw; nexp = 0;
    case (op)
      3'd0: if (fb != w[27:20]) begin
        w[1] = 1'b1; push_exp(w);
        w[2] = 1'b1; push_exp(w);
        w[27:20] = fb; w[18:16] = od; push_exp(w);
        w[2] = 1'b0; push_exp(w);
        w[0] = 1'b1; push_exp(w);
        w[1] = 1'b0; push_exp(w);
      end else begin
        sb = w[1];
        w[1] = 1'b1; push_exp(w);
        w[18:16] = od; push_exp(w);
        w[1] = sb; push_exp(w);
      end
      3'd1: begin w[2] = 1'b0; push_exp(w); end
      3'd2: begin w[2] = 1'b1; push_exp(w); end
      3'd3: begin w[0] = 1'b1; push_exp(w); end
      3'd4: begin w[0] = 1'b0; push_exp(w); end
      default: ;
    endcase
    mw = w;
  endtask

  function automatic string tag_of(logic [2:0] op, logic [7:0] fb);
    case (op)
      3'd0: return (fb != mw[27:20]) ? "R2" : "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3, 3'd4: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic start_log();
    @(negedge clk);
    last_seen = ctrl_word[27:0];
    nseen = 0;
    logging = 1;
  endtask

  task automatic send(logic [2:0] op, logic [7:0] fb, logic [2:0] od);
    @(negedge clk);
    req_op = op; req_fbdiv = fb; req_odiv = od; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (n < 3000) begin
      @(negedge clk);
      n++;
      if (done) break;
    end
    chk(done === 1'b1, "R11", "done seen", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk(!done && !busy && req_ready, "R11", "done one cycle, idle",
        {29'd0, done, busy, req_ready}, 32'd1);
    logging = 0;
  endtask

  task automatic compare_log(string tag);
    chk(nseen == nexp, tag, "number of word writes", nseen, nexp);
    for (int i = 0; i < nexp && i < nseen && i < 16; i++) begin
      chk(seen[i] == expv[i], tag, "word step", {4'd0, seen[i]}, {4'd0, expv[i]});
      if (i > 0)
        chk(seen_cyc[i] - seen_cyc[i-1] >= HOLD, "R8", "hold between writes",
            seen_cyc[i] - seen_cyc[i-1], HOLD);
    end
  endtask

  // {op, fbdiv, odiv, expected number of visible word changes}
  localparam logic [17:0] VEC [12] = '{
    {3'd1, 8'd0,  3'd0, 4'd1},
    {3'd3, 8'd0,  3'd0, 4'd1},
    {3'd0, 8'd39, 3'd1, 4'd3},
    {3'd0, 8'd49, 3'd1, 4'd5},
    {3'd4, 8'd0,  3'd0, 4'd1},
    {3'd0, 8'd49, 3'd1, 4'd2},
    {3'd0, 8'd20, 3'd3, 4'd6},
    {3'd2, 8'd0,  3'd0, 4'd1},
    {3'd0, 8'd30, 3'd0, 4'd4},
    {3'd6, 8'd0,  3'd0, 4'd0},
    {3'd1, 8'd0,  3'd0, 4'd0},
    {3'd4, 8'd0,  3'd0, 4'd1}
  };

  initial begin
    int n;
    string tg;
    logic [31:0] rw;
    rw = (32'd39 << 20) | (32'd2 << 16) | (32'd3 << 8) | (32'd5 << 4) | 32'd4;
    mw = rw;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_word == rw, "R1", "reset word", ctrl_word, rw);
    chk(!busy && req_ready && !done && !req_err, "R1", "reset handshake",
        {28'd0, busy, req_ready, done, req_err}, 32'h4);

    for (int v = 0; v < 12; v++) begin
      tg = tag_of(VEC[v][17:15], VEC[v][14:7]);
      model_op(VEC[v][17:15], VEC[v][14:7], VEC[v][6:4]);
      start_log();
      send(VEC[v][17:15], VEC[v][14:7], VEC[v][6:4]);
      wait_done(n);
      compare_log(tg);
      chk(nseen == int'(VEC[v][3:0]), tg, "table change count", nseen, VEC[v][3:0]);
      chk(ctrl_word[27:0] == mw[27:0], tg, "final word", ctrl_word, mw);
      if (v == 0)
        chk(n > 14 && ctrl_word[29] && ctrl_word[28], "R5", "prepare waited for locks",
            n, 15);
    end

    // R3: long lock without basic lock must stall before enable.
    hold_basic = 1;
    model_op(3'd0, 8'd40, 3'd2);
    start_log();
    send(3'd0, 8'd40, 3'd2);
    repeat (80) @(negedge clk);
    chk(busy && pll_lock_long && !ctrl_word[0] && ctrl_word[1] && !ctrl_word[2],
        "R3", "stalled with only long lock", ctrl_word, 32'h2);
    hold_basic = 0;
    wait_done(n);
    compare_log("R3");
    chk(ctrl_word[0] && !ctrl_word[1], "R3", "enabled after both locks", ctrl_word[1:0], 2'b01);

    // R9: a disable sent while busy is dropped and flagged.
    model_op(3'd0, 8'd40, 3'd5);
    start_log();
    send(3'd0, 8'd40, 3'd5);
    req_op = 3'd4; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err === 1'b1, "R9", "error pulse", req_err, 1);
    @(negedge clk);
    chk(req_err === 1'b0, "R9", "error pulse one cycle", req_err, 0);
    wait_done(n);
    compare_log("R9");
    chk(ctrl_word[0] === 1'b1, "R9", "dropped disable had no effect", ctrl_word[0], 1);

    // R10: readback of lock status and reserved bits.
    chk(ctrl_word[31:28] == 4'b0011 && !ctrl_word[19] && ctrl_word[15:13] == 3'd0 &&
        !ctrl_word[7], "R10", "readback bits", ctrl_word, {4'b0011, 28'd0} | (ctrl_word & 32'h0FF71F7F));
    chk(ctrl_word[12:3] == rw[12:3], "R10", "static fields", ctrl_word[12:3], rw[12:3]);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule